// File: doc/BRIEF.md
# Paged Flash Window Decoder

This block lets a processor with a 16-bit address bus reach two byte-wide parallel flash devices of 512K bytes each. Each device is cut into 32 pages of 16K bytes. A 5-bit page register, loaded through a dedicated I/O write strobe, supplies the upper flash address bits. The lower 14 bits come straight from the processor address.

Two adjacent 16K windows sit in the upper half of the processor's address space. The lower window opens the current page of device A and the upper window opens the same page of device B. The block decodes the top address nibble into one active-low chip select per device. It gates the processor's read and write strobes into a shared output enable and a shared write enable. Each enable is only active while one of the devices is selected.

Addresses in the lower half of the space select no device, so other memories or peripherals can use that range. The decode and strobe gating are combinational. The page register is the only storage. It is cleared by an asynchronous active-low reset whose release is synchronized to the clock.

Top module: `pflash_window`

## Requirements
- R1: After reset the page register holds 0, so flash_addr[18:14] reads 0.
- R2: At a rising clock edge where page_wr_n is low, the page register takes cpu_data[4:0]. From then on flash_addr[18:14] shows that value.
- R3: At a rising clock edge where page_wr_n is high, the page register keeps its value.
- R4: flash_addr always equals {page, cpu_addr[13:0]}: page in bits 18:14 and the processor offset in bits 13:0.
- R5: For cpu_addr 0x8000–0xBFFF (top nibble 8 to B), cs_n[0] (device A) is low and cs_n[1] is high.
- R6: For cpu_addr 0xC000–0xFFFF (top nibble C to F), cs_n[1] (device B) is low and cs_n[0] is high.
- R7: For cpu_addr below 0x8000, both chip selects are high.
- R8: we_n is low exactly when one chip select is low and wr_n is low.
- R9: oe_n is low exactly when one chip select is low and rd_n is low.
- R10: At no time are both chip selects low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the page register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | Processor address bus |
| cpu_data | input | 5 | Low processor data bits, the page number source |
| page_wr_n | input | 1 | Active-low I/O strobe that loads the page register |
| rd_n | input | 1 | Active-low processor read strobe |
| wr_n | input | 1 | Active-low processor write strobe |
| flash_addr | output | 19 | Byte address driven to both flash devices |
| cs_n | output | 2 | Active-low chip selects, bit 0 device A, bit 1 device B |
| oe_n | output | 1 | Active-low output enable to the flash devices |
| we_n | output | 1 | Active-low write enable to the flash devices |

## Verification
The hardest case to reach is a page change that lands between two accesses to the same offset. That is the only moment the upper address bits may move while the lower ones stay put. It is also where a stale or half-loaded page would show.

The stimulus mixes random page loads with random accesses. Directed sequences cover several cases:
- loading a page and then touching the same offset in both windows;
- the window boundaries 0x7FFF, 0x8000, 0xBFFF, 0xC000 and 0xFFFF;
- the extreme pages 0 and 31;
- both strobes low together, and strobes outside any window.

// File: rtl/pflash_window_pkg.sv
package pflash_window_pkg;

  localparam int unsigned CPU_AW_DEF  = 16;
  localparam int unsigned OFFS_W_DEF  = 14;
  localparam int unsigned PAGE_W_DEF  = 5;
  localparam int unsigned N_DEV_DEF   = 2;
  localparam int unsigned WIN0_DEF    = 2;

  // Window index of an address: the bits above the in-page offset.
  function automatic int unsigned win_index(input int unsigned addr,
                                            input int unsigned offs_w);
    return addr >> offs_w;
  endfunction

endpackage

// File: rtl/pflash_rst_sync.sv
module pflash_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pflash_page_reg.sv
module pflash_page_reg #(
  parameter int unsigned PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic [PAGE_W-1:0] page_in,
  output logic [PAGE_W-1:0] page_out
);

  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] page_d;
  logic              page_en;

  always_comb begin
    page_en = ~load_n;
    page_d  = page_q;
    if (page_en) begin
      page_d = page_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (page_en) begin
      page_q <= page_d;
    end
  end

  assign page_out = page_q;

endmodule

// File: rtl/pflash_win_decode.sv
module pflash_win_decode #(
  parameter int unsigned CPU_AW = 16,
  parameter int unsigned OFFS_W = 14,
  parameter int unsigned N_DEV  = 2,
  parameter int unsigned WIN0   = 2
) (
  input  logic [CPU_AW-1:0] addr,
  output logic [N_DEV-1:0]  dev_sel
);

  localparam int unsigned WIN_W = CPU_AW - OFFS_W;

  logic [WIN_W-1:0] win;
  assign win = addr[CPU_AW-1:OFFS_W];

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    localparam logic [WIN_W-1:0] MY_WIN = WIN_W'(WIN0 + d);
    assign dev_sel[d] = (win == MY_WIN);
  end

endmodule

// File: rtl/pflash_strobe_gate.sv
module pflash_strobe_gate #(
  parameter int unsigned N_DEV = 2
) (
  input  logic [N_DEV-1:0] dev_sel,
  input  logic             rd_n,
  input  logic             wr_n,
  output logic [N_DEV-1:0] cs_n,
  output logic             oe_n,
  output logic             we_n
);

  logic any_sel;

  always_comb begin
    any_sel = |dev_sel;
    cs_n    = ~dev_sel;
    oe_n    = ~(any_sel & ~rd_n);
    we_n    = ~(any_sel & ~wr_n);
  end

endmodule

// File: rtl/pflash_window.sv
module pflash_window
  import pflash_window_pkg::*;
#(
  parameter int unsigned CPU_AW = CPU_AW_DEF,
  parameter int unsigned OFFS_W = OFFS_W_DEF,
  parameter int unsigned PAGE_W = PAGE_W_DEF,
  parameter int unsigned N_DEV  = N_DEV_DEF,
  parameter int unsigned WIN0   = WIN0_DEF,
  localparam int unsigned FA_W  = PAGE_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [PAGE_W-1:0] cpu_data,
  input  logic              page_wr_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [FA_W-1:0]   flash_addr,
  output logic [N_DEV-1:0]  cs_n,
  output logic              oe_n,
  output logic              we_n
);

  logic              rst_n_sync;
  logic [PAGE_W-1:0] page;
  logic [N_DEV-1:0]  dev_sel;

  pflash_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pflash_page_reg #(.PAGE_W(PAGE_W)) i_page_reg (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load_n   (page_wr_n),
    .page_in  (cpu_data),
    .page_out (page)
  );

  pflash_win_decode #(
    .CPU_AW (CPU_AW),
    .OFFS_W (OFFS_W),
    .N_DEV  (N_DEV),
    .WIN0   (WIN0)
  ) i_win_decode (
    .addr    (cpu_addr),
    .dev_sel (dev_sel)
  );

  pflash_strobe_gate #(.N_DEV(N_DEV)) i_strobe_gate (
    .dev_sel (dev_sel),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .cs_n    (cs_n),
    .oe_n    (oe_n),
    .we_n    (we_n)
  );

  assign flash_addr = {page, cpu_addr[OFFS_W-1:0]};

endmodule

// File: rtl/pflash_window_chk.sv
module pflash_window_chk #(
  parameter int unsigned CPU_AW = 16,
  parameter int unsigned OFFS_W = 14,
  parameter int unsigned PAGE_W = 5,
  parameter int unsigned N_DEV  = 2
) (
  input logic                     clk,
  input logic                     rst_n_sync,
  input logic [CPU_AW-1:0]        cpu_addr,
  input logic [PAGE_W-1:0]        cpu_data,
  input logic                     page_wr_n,
  input logic                     rd_n,
  input logic                     wr_n,
  input logic [PAGE_W+OFFS_W-1:0] flash_addr,
  input logic [N_DEV-1:0]         cs_n,
  input logic                     oe_n,
  input logic                     we_n
);

  localparam int unsigned FA_W = PAGE_W + OFFS_W;

  assert_page_load_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !page_wr_n |=> flash_addr[FA_W-1:OFFS_W] == $past(cpu_data));

  assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    page_wr_n |=> flash_addr[FA_W-1:OFFS_W] == $past(flash_addr[FA_W-1:OFFS_W]));

  assert_offset_pass_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    flash_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0]);

  assert_low_half_idle_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !cpu_addr[CPU_AW-1] |-> (&cs_n && oe_n && we_n));

  assert_we_gated_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !we_n |-> (!wr_n && !(&cs_n)));

  assert_oe_gated_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !oe_n |-> (!rd_n && !(&cs_n)));

  assert_one_device_R10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $onehot0(~cs_n));

endmodule

bind pflash_window pflash_window_chk #(
  .CPU_AW (CPU_AW),
  .OFFS_W (OFFS_W),
  .PAGE_W (PAGE_W),
  .N_DEV  (N_DEV)
) i_pflash_window_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .cpu_addr   (cpu_addr),
  .cpu_data   (cpu_data),
  .page_wr_n  (page_wr_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .flash_addr (flash_addr),
  .cs_n       (cs_n),
  .oe_n       (oe_n),
  .we_n       (we_n)
);

// File: tb/test_pflash_window.sv
`timescale 1ns/1ps
module test_pflash_window;

  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [4:0]  cpu_data;
  logic        page_wr_n;
  logic        rd_n;
  logic        wr_n;
  logic [18:0] flash_addr;
  logic [1:0]  cs_n;
  logic        oe_n;
  logic        we_n;

  int n_chk;
  int n_fail;
  logic [4:0] m_page;
  logic done;

  pflash_window i_pflash_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_data   (cpu_data),
    .page_wr_n  (page_wr_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .flash_addr (flash_addr),
    .cs_n       (cs_n),
    .oe_n       (oe_n),
    .we_n       (we_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [1:0] exp_cs(input logic [15:0] a);
    if (a >= 16'hC000)      return 2'b01;
    else if (a >= 16'h8000) return 2'b10;
    else                    return 2'b11;
  endfunction

  function automatic logic exp_en(input logic [15:0] a, input logic strobe_n);
    return !((exp_cs(a) != 2'b11) && !strobe_n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R4 flash address", 32'(flash_addr), 32'({m_page, cpu_addr[13:0]}));
    if (cpu_addr < 16'h8000)      chk("R7 no select below window", 32'(cs_n), 32'(exp_cs(cpu_addr)));
    else if (cpu_addr < 16'hC000) chk("R5 device A select", 32'(cs_n), 32'(exp_cs(cpu_addr)));
    else                          chk("R6 device B select", 32'(cs_n), 32'(exp_cs(cpu_addr)));
    chk("R8 write enable", 32'(we_n), 32'(exp_en(cpu_addr, wr_n)));
    chk("R9 output enable", 32'(oe_n), 32'(exp_en(cpu_addr, rd_n)));
    chk("R10 single select", 32'(cs_n != 2'b00), 32'd1);
  endtask

  task automatic access(input logic [15:0] a, input logic r, input logic w);
    @(negedge clk);
    cpu_addr = a; rd_n = r; wr_n = w;
    #1 check_all();
  endtask

  task automatic load_page(input logic [4:0] p);
    @(negedge clk);
    cpu_data = p; page_wr_n = 1'b0;
    @(negedge clk);
    page_wr_n = 1'b1;
    cpu_data = ~p;
    m_page = p;
    #1 chk("R2 page load", 32'(flash_addr[18:14]), 32'(p));
  endtask

  task automatic idle_cycle(input logic [4:0] junk);
    @(negedge clk);
    cpu_data = junk;
    @(negedge clk);
    #1 chk("R3 page hold", 32'(flash_addr[18:14]), 32'(m_page));
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    n_chk = 0; n_fail = 0; m_page = 5'd0;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0; cpu_addr = 16'h0000; cpu_data = 5'd0;
    page_wr_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cpu_addr = 16'h8123;
    #1 chk("R1 reset page", 32'(flash_addr[18:14]), 32'd0);
    check_all();

    // R5/R6/R7 window boundaries
    access(16'h7FFF, 1'b0, 1'b1);
    access(16'h8000, 1'b0, 1'b1);
    access(16'hBFFF, 1'b1, 1'b0);
    access(16'hC000, 1'b1, 1'b0);
    access(16'hFFFF, 1'b0, 1'b0);
    access(16'h0000, 1'b0, 1'b0);

    // extreme pages, same offset in both windows
    load_page(5'd31);
    access(16'h9ABC, 1'b0, 1'b1);
    access(16'hDABC, 1'b0, 1'b1);
    idle_cycle(5'd7);
    load_page(5'd0);
    access(16'h9ABC, 1'b1, 1'b0);
    access(16'hDABC, 1'b1, 1'b0);
    load_page(5'd21);
    idle_cycle(5'd10);

    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom;
      if (r[2:0] == 3'd0) load_page(5'($urandom));
      else if (r[2:0] == 3'd1) idle_cycle(5'($urandom));
      else access(16'($urandom), r[3], r[4]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule